// File: doc/BRIEF.md
# Streaming Pixel Effect Processor

This block sits in a video stream and rewrites each 32-bit RGB pixel (blue in bits [7:0], green in [15:8], red in [23:16], bits [31:24] a spare byte) as it passes through. A frame is 640 columns by 480 rows, sent in raster order. The first pixel of each frame carries a start-of-frame flag. Both the input and the output are valid/ready streams. One register stage sits between them, and the block accepts a new pixel on every cycle in which the downstream side can take one.

A 2-bit effect select picks what happens to the frame. Code 0 leaves pixels untouched. Code 1 overlays a grid of white dots. Code 2 inverts the colour. Code 3 cuts the screen into quarters, each with its own treatment. The select is configuration: the block samples it together with the start-of-frame pixel and holds it for the rest of that frame. The block keeps its own column and row count, so the upstream side sends only pixels and the frame marker. The output carries the marker forward and adds an end-of-frame flag on the final pixel.

Top module: `pfx_stream_fx`

## Requirements
- R1: After reset, out_valid is low and in_ready is high.
- R2: With effect code 0, every output pixel equals its input pixel.
- R3: With effect code 1, a pixel whose column and row are both multiples of 4 leaves with bits [23:0] set to all ones and bits [31:24] kept. Every other pixel leaves unchanged.
- R4: With effect code 2, each of the three 8-bit channels in bits [23:0] becomes 255 minus its value, and bits [31:24] are kept.
- R5: With effect code 3, the effect depends on position. Pixels with column below 320 and row below 240 pass through. Pixels with column 320 or above and row below 240 get the R3 dots. Pixels with column below 320 and row 240 or above get the R4 inversion. Pixels with column 320 or above and row 240 or above have each of the three channels halved (shifted right by one), with bits [31:24] kept.
- R6: The effect code is sampled on the accepted beat that carries in_sof. A different code presented on later beats of the same frame does not change that frame's output.
- R7: The column advances by one on each accepted beat and wraps from 639 to 0. The row advances on that wrap and wraps from 479 to 0. An accepted beat with in_sof high is always at column 0, row 0, even if the previous frame was cut short.
- R8: out_sof marks the output of the start-of-frame pixel. out_eof is high only on the output of the pixel at column 639, row 479.
- R9: An accepted pixel appears on the output on the next cycle. Output pixels keep input order. While out_valid is high and out_ready is low, the output stays unchanged.
- R10: in_ready is high in every cycle in which out_ready is high, so a stream runs at one pixel per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Effect select, sampled with the start-of-frame beat |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block can take an input pixel |
| in_data | input | 32 | Input pixel |
| in_sof | input | 1 | Input pixel is the first of a frame |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Downstream can take the output pixel |
| out_data | output | 32 | Processed pixel |
| out_sof | output | 1 | Output pixel is the first of a frame |
| out_eof | output | 1 | Output pixel is the last of a frame |

## Verification
A wrong column or row count shows on the next output beat: the dot grid lands on the wrong pixels, a quadrant border moves, or out_eof appears on the wrong beat. A mode register that reloads at the wrong time shows as a different effect partway through a frame. This is visible one cycle after the faulty beat is accepted. The bench runs the design with a reduced frame so that it can check every pixel of several frames against expected values. The dot cells then fall on both sides of each quadrant border, so all of these faults are caught within the first frame that exercises them.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

  localparam int PIX_W = 32;

  typedef enum logic [1:0] {
    FX_PASS   = 2'd0,
    FX_DOTS   = 2'd1,
    FX_INVERT = 2'd2,
    FX_QUAD   = 2'd3
  } fx_mode_e;

  // Spare byte kept, colour bits forced to white.
  function automatic logic [PIX_W-1:0] fx_whiten(input logic [PIX_W-1:0] p);
    return {p[31:24], 24'hFF_FFFF};
  endfunction

  // Each colour channel complemented (255 - x).
  function automatic logic [PIX_W-1:0] fx_invert(input logic [PIX_W-1:0] p);
    return {p[31:24], ~p[23:16], ~p[15:8], ~p[7:0]};
  endfunction

  // Each colour channel halved.
  function automatic logic [PIX_W-1:0] fx_darken(input logic [PIX_W-1:0] p);
    return {p[31:24], 1'b0, p[23:17], 1'b0, p[15:9], 1'b0, p[7:1]};
  endfunction

endpackage

// File: rtl/pfx_position.sv
module pfx_position #(
  parameter int WIDTH    = 640,
  parameter int HEIGHT   = 480,
  parameter int DOT_STEP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic beat,
  input  logic sof,
  output logic on_dot,
  output logic in_top,
  output logic in_left,
  output logic frame_end
);
  localparam int COL_W  = (WIDTH  > 1) ? $clog2(WIDTH)  : 1;
  localparam int ROW_W  = (HEIGHT > 1) ? $clog2(HEIGHT) : 1;
  localparam int DOT_LG = (DOT_STEP > 1) ? $clog2(DOT_STEP) : 1;
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(WIDTH - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(HEIGHT - 1);
  localparam logic [COL_W-1:0] COL_HALF = COL_W'(WIDTH / 2);
  localparam logic [ROW_W-1:0] ROW_HALF = ROW_W'(HEIGHT / 2);

  logic [COL_W-1:0] col_q, cur_col;
  logic [ROW_W-1:0] row_q, cur_row;
  logic             col_wrap, row_wrap;

  // A start-of-frame beat is always position (0,0).
  assign cur_col  = sof ? '0 : col_q;
  assign cur_row  = sof ? '0 : row_q;
  assign col_wrap = (cur_col == COL_LAST);
  assign row_wrap = (cur_row == ROW_LAST);
  assign frame_end = col_wrap && row_wrap;
  assign in_top   = (cur_row < ROW_HALF);
  assign in_left  = (cur_col < COL_HALF);

  generate
    if (DOT_STEP > 1) begin : g_dot_grid
      assign on_dot = (cur_col[DOT_LG-1:0] == '0) && (cur_row[DOT_LG-1:0] == '0);
    end else begin : g_dot_all
      assign on_dot = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else if (beat) begin
      col_q <= col_wrap ? '0 : cur_col + COL_W'(1);
      if (col_wrap) row_q <= row_wrap ? '0 : cur_row + ROW_W'(1);
      else          row_q <= cur_row;
    end
  end

  // R7
  col_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat && col_wrap |=> col_q == '0);
  // R7
  row_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat && frame_end |=> row_q == '0 && col_q == '0);
  // R7
  col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_q <= COL_LAST && row_q <= ROW_LAST);
  // R7
  col_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !beat |=> $stable(col_q) && $stable(row_q));

endmodule

// File: rtl/pfx_mode_latch.sv
module pfx_mode_latch
  import pfx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       beat,
  input  logic       sof,
  input  logic [1:0] mode_i,
  output fx_mode_e   mode_eff
);
  fx_mode_e mode_q;
  logic     mode_load;

  assign mode_load = beat && sof;
  // The start-of-frame pixel itself already uses the new code.
  assign mode_eff  = sof ? fx_mode_e'(mode_i) : mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         mode_q <= FX_PASS;
    else if (mode_load) mode_q <= fx_mode_e'(mode_i);
  end

  // R6
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_load |=> $stable(mode_q));
  // R6
  mode_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_load |=> mode_q == $past(mode_i));

endmodule

// File: rtl/pfx_effect.sv
module pfx_effect
  import pfx_pkg::*;
(
  input  fx_mode_e         mode,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             on_dot,
  input  logic             in_top,
  input  logic             in_left,
  output logic [PIX_W-1:0] pix_o
);
  logic [PIX_W-1:0] dotted;

  assign dotted = on_dot ? fx_whiten(pix_i) : pix_i;

  always_comb begin
    unique case (mode)
      FX_PASS:   pix_o = pix_i;
      FX_DOTS:   pix_o = dotted;
      FX_INVERT: pix_o = fx_invert(pix_i);
      FX_QUAD: begin
        unique case ({in_top, in_left})
          2'b11:   pix_o = pix_i;
          2'b10:   pix_o = dotted;
          2'b01:   pix_o = fx_invert(pix_i);
          default: pix_o = fx_darken(pix_i);
        endcase
      end
      default:   pix_o = pix_i;
    endcase
  end

endmodule

// File: rtl/pfx_stream_fx.sv
module pfx_stream_fx
  import pfx_pkg::*;
#(
  parameter int WIDTH    = 640,
  parameter int HEIGHT   = 480,
  parameter int DOT_STEP = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  mode_i,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  input  logic        in_sof,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data,
  output logic        out_sof,
  output logic        out_eof
);
  logic             beat;
  logic             on_dot, in_top, in_left, frame_end;
  fx_mode_e         mode_eff;
  logic [PIX_W-1:0] fx_pix;

  assign in_ready = !out_valid || out_ready;
  assign beat     = in_valid && in_ready;

  pfx_position #(
    .WIDTH(WIDTH), .HEIGHT(HEIGHT), .DOT_STEP(DOT_STEP)
  ) u_pos (
    .clk(clk), .rst_n(rst_n), .beat(beat), .sof(in_sof),
    .on_dot(on_dot), .in_top(in_top), .in_left(in_left),
    .frame_end(frame_end)
  );

  pfx_mode_latch u_mode (
    .clk(clk), .rst_n(rst_n), .beat(beat), .sof(in_sof),
    .mode_i(mode_i), .mode_eff(mode_eff)
  );

  pfx_effect u_fx (
    .mode(mode_eff), .pix_i(in_data), .on_dot(on_dot),
    .in_top(in_top), .in_left(in_left), .pix_o(fx_pix)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (beat) begin
        out_data <= fx_pix;
        out_sof  <= in_sof;
        out_eof  <= frame_end;
      end
    end
  end

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)
                                && $stable(out_sof) && $stable(out_eof));
  // R9
  beat_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat |=> out_valid);
  // R8
  sof_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sof && out_eof |-> (WIDTH * HEIGHT == 1));

endmodule

// File: tb/sim_pfx_stream_fx.sv
module sim_pfx_stream_fx;
  localparam int W = 8;
  localparam int H = 6;
  localparam int DS = 4;
  localparam int QN = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        in_sof = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic        out_sof;
  logic        out_eof;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit bp_en = 1'b0;
  int pat = 0;

  logic [31:0] exp_data [QN];
  bit          exp_sof  [QN];
  bit          exp_eof  [QN];
  int          exp_cyc  [QN];
  bit          exp_tmg  [QN];
  string       exp_req  [QN];
  int wr_i = 0;
  int rd_i = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pfx_stream_fx #(.WIDTH(W), .HEIGHT(H), .DOT_STEP(DS)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_sof(in_sof),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof)
  );

  always @(negedge clk) begin
    pat <= pat + 1;
    out_ready <= bp_en ? ((pat % 3) != 1) : 1'b1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] ch(input logic [31:0] p, input int k);
    return p[k*8 +: 8];
  endfunction

  function automatic logic [31:0] model(input int m, input int r, input int c,
                                        input logic [31:0] p);
    logic [31:0] q;
    int eff;
    eff = m;
    if (m == 3) begin
      if (r < H/2) eff = (c < W/2) ? 0 : 1;
      else         eff = (c < W/2) ? 2 : 4;
    end
    q = p;
    case (eff)
      1: if ((r % DS == 0) && (c % DS == 0))
           for (int k = 0; k < 3; k++) q[k*8 +: 8] = 8'd255;
      2: for (int k = 0; k < 3; k++) q[k*8 +: 8] = 8'(255 - int'(ch(p, k)));
      4: for (int k = 0; k < 3; k++) q[k*8 +: 8] = 8'(int'(ch(p, k)) / 2);
      default: ;
    endcase
    return q;
  endfunction

  function automatic logic [31:0] pix(input int fr, input int r, input int c);
    return (32'(fr) * 32'h9E37_79B1) ^ (32'(r) << 13) ^ (32'(c) * 32'h0001_0307)
           ^ 32'h5A00_0000;
  endfunction

  task automatic send(input logic [31:0] d, input bit sof, input logic [1:0] m,
                      input logic [31:0] e, input bit eeof, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_sof = sof; mode_i = m;
    #3;
    while (!in_ready) begin
      if (!bp_en) check(1'b0, "R10", "in_ready low with out_ready high", 32'(in_ready), 32'd1);
      @(negedge clk); #3;
    end
    exp_data[wr_i] = e; exp_sof[wr_i] = sof; exp_eof[wr_i] = eeof;
    exp_cyc[wr_i] = cyc; exp_tmg[wr_i] = !bp_en; exp_req[wr_i] = req;
    wr_i++;
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
  endtask

  // Full frame: effect code m0 presented with SOF, m1 on all other beats.
  task automatic send_frame(input int fr, input int m0, input int m1, input string req);
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        bit first;
        first = (r == 0 && c == 0);
        send(pix(fr, r, c), first, first ? 2'(m0) : 2'(m1),
             model(m0, r, c, pix(fr, r, c)), (r == H-1 && c == W-1), req);
      end
  endtask

  // Output monitor, sampling 1 ns before each rising edge.
  always @(negedge clk) begin
    #3;
    if (rst_n && out_valid && out_ready) begin
      if (rd_i >= wr_i) begin
        check(1'b0, "R9", "unexpected output beat", out_data, 32'h0);
      end else begin
        check(out_data === exp_data[rd_i], exp_req[rd_i], "pixel", out_data, exp_data[rd_i]);
        check(out_sof === exp_sof[rd_i] && out_eof === exp_eof[rd_i], "R8", "sof/eof",
              {30'd0, out_sof, out_eof}, {30'd0, exp_sof[rd_i], exp_eof[rd_i]});
        if (exp_tmg[rd_i])
          check(cyc == exp_cyc[rd_i] + 1, "R9", "latency in cycles",
                32'(cyc - exp_cyc[rd_i]), 32'd1);
        rd_i++;
      end
    end
  end

  bit done = 1'b0;
  initial begin
    #(8 * 150000);
    if (!done) begin
      check(1'b0, "R9", "watchdog expired", 32'(rd_i), 32'(wr_i));
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check(out_valid == 1'b0, "R1", "out_valid after reset", 32'(out_valid), 32'd0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", 32'(in_ready), 32'd1);

    send_frame(1, 0, 0, "R2");
    send_frame(2, 1, 1, "R3");
    send_frame(3, 2, 2, "R4");
    send_frame(4, 3, 3, "R5");
    // R6: codes changing on non-SOF beats are ignored.
    send_frame(5, 2, 0, "R6");
    send_frame(6, 3, 1, "R6");
    // R7: cut-short frame, then a new SOF restarts at (0,0).
    for (int c = 0; c < 5; c++)
      send(pix(7, 0, c), c == 0, 2'd2, model(2, 0, c, pix(7, 0, c)), 1'b0, "R7");
    idle();
    send_frame(8, 1, 1, "R7");
    // R9: order and hold under downstream stalls, with gaps.
    bp_en = 1'b1;
    send_frame(9, 3, 2, "R9");
    idle(); idle();
    send_frame(10, 1, 0, "R9");
    idle();
    bp_en = 1'b0;
    // R10: back-to-back frames at full rate, no stalls expected.
    send_frame(11, 2, 2, "R10");
    send_frame(12, 0, 3, "R10");
    idle();

    repeat (20) @(negedge clk);
    check(rd_i == wr_i, "R9", "all beats delivered", 32'(rd_i), 32'(wr_i));
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule